// File: doc/BRIEF.md
# Keyed Register Write-Lock Controller

This block keeps a small group of control registers safe from stray writes. A simple single-cycle register bus (write enable, address, write data) reaches three protected 16-bit registers and one key register. The protected registers stand in for a waveform-generator control word and two fault-response control words. Their contents have no meaning here, so they are modelled as plain storage.

A static configuration input turns protection on or off. With protection off, the protected registers take any write. With protection on, software must first write two agreed values, one after the other, into the key register. That completed handshake allows exactly one write to a protected register. Any other bus activity ends the handshake or the grant. A write that is refused leaves the register untouched and raises a one-cycle violation pulse. A combinational read port returns the register contents. The key register reads back as zero.

Top module: `keylock_ctrl`

## Requirements
- R1: After reset, all three protected registers read 0, the violation output is 0, and no grant is held, so a protected write made straight after reset with protection on is refused.
- R2: The read port returns the protected registers at addresses 0, 1 and 2. It returns 0 at the key address 3 and at every unmapped address (4 to 7).
- R3: When the lock configuration input is 0, a write to any protected address updates that register in the same clock edge and raises no violation.
- R4: When the lock configuration input is 1, a write of 0xABCD to address 3 followed by a write of 0x4321 to address 3 as the next bus write arms a grant. Cycles with no bus write between the two key writes do not break the sequence.
- R5: The key sequence returns to idle on a wrong key value, on a write to any other address between the two key writes, or on 0xABCD when 0x4321 is expected. A write of 0xABCD while the grant is armed restarts the sequence at its first step.
- R6: An armed grant allows exactly one protected write. Any bus write that is not to the key register ends the grant, including a write to an unmapped address.
- R7: A refused protected write leaves every register unchanged. wr_viol_o is 1 for exactly the one cycle after the clock edge of that write.
- R8: Writes to the key register or to unmapped addresses never raise a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_cfg_i | input | 1 | Static protection enable (1 = protected) |
| wr_en_i | input | 1 | Bus write strobe, one write per cycle |
| wr_addr_i | input | 3 | Bus write address |
| wr_data_i | input | 16 | Bus write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 16 | Combinational read data |
| wr_viol_o | output | 1 | One-cycle pulse after a refused write |

## Verification
The hardest states to reach are those where the sequence sits half-done or fully armed and is then disturbed. Examples are a write to an unmapped address between the two key values, a repeat of the first key value, and a fresh first key value while the grant is armed. The stimulus table reaches each of these by placing the key writes, idle cycles and stray writes in exact order. After each disturbance it attempts a protected write, which shows at the ports whether the grant survived.

// File: rtl/keylock_pkg.sv
package keylock_pkg;
  localparam int unsigned REG_W = 16;

  typedef enum logic [1:0] {
    KS_IDLE  = 2'd0,
    KS_HALF  = 2'd1,
    KS_ARMED = 2'd2
  } key_state_e;

  // Next sequence state for one bus write.
  function automatic key_state_e key_step(input key_state_e cur,
                                          input logic is_key,
                                          input logic [REG_W-1:0] val,
                                          input logic [REG_W-1:0] first,
                                          input logic [REG_W-1:0] second);
    key_state_e nxt;
    if (!is_key)                             nxt = KS_IDLE;
    else if (cur == KS_HALF && val == second) nxt = KS_ARMED;
    else if (cur != KS_HALF && val == first)  nxt = KS_HALF;
    else                                      nxt = KS_IDLE;
    return nxt;
  endfunction
endpackage

// File: rtl/keylock_seq.sv
module keylock_seq
  import keylock_pkg::*;
#(
  parameter logic [REG_W-1:0] KEY_FIRST  = 16'hABCD,
  parameter logic [REG_W-1:0] KEY_SECOND = 16'h4321
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             key_hit,
  input  logic [REG_W-1:0] wr_data,
  output logic             armed
);
  key_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state_q <= KS_IDLE;
    else if (wr_en) state_q <= key_step(state_q, key_hit, wr_data, KEY_FIRST, KEY_SECOND);
  end

  assign armed = (state_q == KS_ARMED);
endmodule

// File: rtl/keylock_gate.sv
module keylock_gate #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned N_PROT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_cfg,
  input  logic              armed,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              key_hit,
  output logic [N_PROT-1:0] wr_ok,
  output logic              blocked,
  output logic              viol_q
);
  localparam logic [ADDR_W-1:0] KEY_ADDR = ADDR_W'(N_PROT);

  logic prot_hit;
  logic allowed;

  assign key_hit  = wr_en && (wr_addr == KEY_ADDR);
  assign prot_hit = wr_en && (wr_addr < KEY_ADDR);
  assign allowed  = !lock_cfg || armed;
  assign blocked  = prot_hit && !allowed;

  for (genvar i = 0; i < N_PROT; i++) begin : g_sel
    assign wr_ok[i] = prot_hit && allowed && (wr_addr == ADDR_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) viol_q <= 1'b0;
    else        viol_q <= blocked;
  end
endmodule

// File: rtl/keylock_regs.sv
module keylock_regs
  import keylock_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned N_PROT = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_PROT-1:0]       wr_ok,
  input  logic [REG_W-1:0]        wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [REG_W-1:0]        rd_data,
  output logic [N_PROT*REG_W-1:0] regs_flat
);
  logic [REG_W-1:0] store_q [N_PROT];

  for (genvar i = 0; i < N_PROT; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        store_q[i] <= '0;
      else if (wr_ok[i]) store_q[i] <= wr_data;
    end
    assign regs_flat[i*REG_W +: REG_W] = store_q[i];
  end

  // Key and unmapped addresses read zero.
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_PROT; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_data = store_q[i];
    end
  end
endmodule

// File: rtl/keylock_ctrl.sv
module keylock_ctrl
  import keylock_pkg::*;
#(
  parameter int unsigned      ADDR_W     = 3,
  parameter int unsigned      N_PROT     = 3,
  parameter logic [REG_W-1:0] KEY_FIRST  = 16'hABCD,
  parameter logic [REG_W-1:0] KEY_SECOND = 16'h4321
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_cfg_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              wr_viol_o
);
  logic                    armed_w;
  logic                    key_hit_w;
  logic                    blocked_w;
  logic [N_PROT-1:0]       wr_ok_w;
  logic [N_PROT*REG_W-1:0] regs_w;

  keylock_seq #(.KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .key_hit(key_hit_w),
    .wr_data(wr_data_i), .armed(armed_w)
  );

  keylock_gate #(.ADDR_W(ADDR_W), .N_PROT(N_PROT)) u_gate (
    .clk(clk), .rst_n(rst_n), .lock_cfg(lock_cfg_i), .armed(armed_w),
    .wr_en(wr_en_i), .wr_addr(wr_addr_i), .key_hit(key_hit_w),
    .wr_ok(wr_ok_w), .blocked(blocked_w), .viol_q(wr_viol_o)
  );

  keylock_regs #(.ADDR_W(ADDR_W), .N_PROT(N_PROT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok_w), .wr_data(wr_data_i),
    .rd_addr(rd_addr_i), .rd_data(rd_data_o), .regs_flat(regs_w)
  );
endmodule

// File: rtl/keylock_ctrl_chk.sv
module keylock_ctrl_chk
  import keylock_pkg::*;
#(
  parameter int unsigned      ADDR_W     = 3,
  parameter int unsigned      N_PROT     = 3,
  parameter logic [REG_W-1:0] KEY_SECOND = 16'h4321
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    lock_cfg_i,
  input logic                    wr_en_i,
  input logic [ADDR_W-1:0]       wr_addr_i,
  input logic [REG_W-1:0]        wr_data_i,
  input logic                    wr_viol_o,
  input logic                    armed_w,
  input logic [N_PROT*REG_W-1:0] regs_w
);
  localparam logic [ADDR_W-1:0] KEY_ADDR = ADDR_W'(N_PROT);

  logic prot_wr;
  assign prot_wr = wr_en_i && (wr_addr_i < KEY_ADDR);

  p_arm_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_w) |-> $past(wr_en_i && wr_addr_i == KEY_ADDR && wr_data_i == KEY_SECOND));

  p_one_shot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_w && wr_en_i && wr_addr_i != KEY_ADDR) |=> !armed_w);

  p_blocked_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_wr && lock_cfg_i && !armed_w) |=> (wr_viol_o && $stable(regs_w)));

  p_viol_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_viol_o |-> $past(prot_wr && lock_cfg_i && !armed_w));

  p_open_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_wr && !lock_cfg_i) |=> !wr_viol_o);

  p_nonprot_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i >= KEY_ADDR) |=> !wr_viol_o);
endmodule

bind keylock_ctrl keylock_ctrl_chk #(
  .ADDR_W(ADDR_W), .N_PROT(N_PROT), .KEY_SECOND(KEY_SECOND)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lock_cfg_i(lock_cfg_i), .wr_en_i(wr_en_i),
  .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .wr_viol_o(wr_viol_o),
  .armed_w(armed_w), .regs_w(regs_w)
);

// File: tb/keylock_ctrl_bench.sv
module keylock_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lock_cfg = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        viol;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  keylock_ctrl u_keylock_ctrl (
    .clk(clk), .rst_n(rst_n), .lock_cfg_i(lock_cfg), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .wr_viol_o(viol)
  );

  // {we, addr, data, lock, rd_addr, exp_rd, exp_viol, req}
  localparam int NV = 35;
  localparam logic [44:0] VEC [NV] = '{
    {1'b1,3'd0,16'h1111,1'b1,3'd0,16'h0000,1'b1,4'd7}, // R7 refused, no key
    {1'b1,3'd3,16'hABCD,1'b1,3'd3,16'h0000,1'b0,4'd2}, // R2 key reads 0
    {1'b1,3'd3,16'h4321,1'b1,3'd3,16'h0000,1'b0,4'd8}, // R8 key write quiet
    {1'b1,3'd0,16'h1111,1'b1,3'd0,16'h1111,1'b0,4'd4}, // R4 granted
    {1'b1,3'd0,16'h2222,1'b1,3'd0,16'h1111,1'b1,4'd6}, // R6 grant spent
    {1'b1,3'd3,16'hABCD,1'b1,3'd0,16'h1111,1'b0,4'd4},
    {1'b0,3'd0,16'h0000,1'b1,3'd0,16'h1111,1'b0,4'd4}, // R4 idle gap
    {1'b1,3'd3,16'h4321,1'b1,3'd0,16'h1111,1'b0,4'd4},
    {1'b1,3'd1,16'h3333,1'b1,3'd1,16'h3333,1'b0,4'd4}, // R4 gap kept seq
    {1'b1,3'd3,16'hABCD,1'b1,3'd1,16'h3333,1'b0,4'd5},
    {1'b1,3'd5,16'h0000,1'b1,3'd5,16'h0000,1'b0,4'd8}, // R8 unmapped quiet
    {1'b1,3'd3,16'h4321,1'b1,3'd2,16'h0000,1'b0,4'd5},
    {1'b1,3'd2,16'h5555,1'b1,3'd2,16'h0000,1'b1,4'd5}, // R5 interleave
    {1'b1,3'd3,16'hABCD,1'b1,3'd2,16'h0000,1'b0,4'd5},
    {1'b1,3'd3,16'h1234,1'b1,3'd2,16'h0000,1'b0,4'd5},
    {1'b1,3'd3,16'h4321,1'b1,3'd2,16'h0000,1'b0,4'd5},
    {1'b1,3'd2,16'h6666,1'b1,3'd2,16'h0000,1'b1,4'd5}, // R5 wrong value
    {1'b1,3'd3,16'h4321,1'b1,3'd0,16'h1111,1'b0,4'd5},
    {1'b1,3'd0,16'h7777,1'b1,3'd0,16'h1111,1'b1,4'd5}, // R5 second alone
    {1'b1,3'd3,16'hABCD,1'b1,3'd1,16'h3333,1'b0,4'd6},
    {1'b1,3'd3,16'h4321,1'b1,3'd1,16'h3333,1'b0,4'd6},
    {1'b1,3'd6,16'h0001,1'b1,3'd6,16'h0000,1'b0,4'd2}, // R2 unmapped reads 0
    {1'b1,3'd1,16'h7777,1'b1,3'd1,16'h3333,1'b1,4'd6}, // R6 stray write ends grant
    {1'b1,3'd3,16'hABCD,1'b1,3'd2,16'h0000,1'b0,4'd5},
    {1'b1,3'd3,16'h4321,1'b1,3'd2,16'h0000,1'b0,4'd5},
    {1'b1,3'd3,16'hABCD,1'b1,3'd2,16'h0000,1'b0,4'd5},
    {1'b1,3'd3,16'h4321,1'b1,3'd2,16'h0000,1'b0,4'd5},
    {1'b1,3'd2,16'h8888,1'b1,3'd2,16'h8888,1'b0,4'd5}, // R5 restart from armed
    {1'b1,3'd3,16'hABCD,1'b1,3'd0,16'h1111,1'b0,4'd5},
    {1'b1,3'd3,16'hABCD,1'b1,3'd0,16'h1111,1'b0,4'd5},
    {1'b1,3'd3,16'h4321,1'b1,3'd0,16'h1111,1'b0,4'd5},
    {1'b1,3'd0,16'hBBBB,1'b1,3'd0,16'h1111,1'b1,4'd5}, // R5 repeated first
    {1'b1,3'd0,16'h9999,1'b0,3'd0,16'h9999,1'b0,4'd3}, // R3 open
    {1'b1,3'd1,16'hAAAA,1'b0,3'd1,16'hAAAA,1'b0,4'd3}, // R3 open
    {1'b1,3'd2,16'hCCCC,1'b1,3'd2,16'h8888,1'b1,4'd7}  // R7 locked again
  };

  task automatic check(input string tag, input logic [15:0] got_rd, input logic [15:0] exp_rd,
                       input logic got_v, input logic exp_v);
    n_chk++;
    if (got_rd !== exp_rd || got_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s: rd=%h viol=%b expected rd=%h viol=%b", tag, got_rd, got_v, exp_rd, exp_v);
    end
  endtask

  task automatic step(input logic we, input logic [2:0] a, input logic [15:0] d,
                      input logic lk, input logic [2:0] ra);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; lock_cfg = lk; rd_addr = ra;
    @(posedge clk);
    #4;
    wr_en = 1'b0;
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 3; a++) begin
      rd_addr = 3'(a);
      #1 check("R1 reset value", rd_data, 16'h0000, viol, 1'b0);
    end
    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [44:0] v;
      string tag;
      v = VEC[i];
      step(v[44], v[43:41], v[40:25], v[24], v[23:21]);
      tag = $sformatf("R%0d vec%0d", v[3:0], i);
      check(tag, rd_data, v[20:5], viol, v[4]);
    end
    // R7 pulse lasts one cycle only
    step(1'b0, 3'd0, 16'h0, 1'b1, 3'd2);
    check("R7 pulse width", rd_data, 16'h8888, viol, 1'b0);
    // R4 several idle cycles between key values
    step(1'b1, 3'd3, 16'hABCD, 1'b1, 3'd1);
    for (int k = 0; k < 3; k++) step(1'b0, 3'd0, 16'h0, 1'b1, 3'd1);
    step(1'b1, 3'd3, 16'h4321, 1'b1, 3'd1);
    step(1'b1, 3'd1, 16'hCCCC, 1'b1, 3'd1);
    check("R4 long gap", rd_data, 16'hCCCC, viol, 1'b0);
    // R1 reset clears registers and the grant
    step(1'b1, 3'd3, 16'hABCD, 1'b1, 3'd0);
    step(1'b1, 3'd3, 16'h4321, 1'b1, 3'd0);
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    for (int a = 0; a < 3; a++) begin
      rd_addr = 3'(a);
      #1 check("R1 reset clears", rd_data, 16'h0000, viol, 1'b0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 3'd0, 16'h5A5A, 1'b1, 3'd0);
    check("R1 grant dropped by reset", rd_data, 16'h0000, viol, 1'b1);
    finish_run();
  end
endmodule